// File: doc/BRIEF.md
# Four-Word Burst Address Sequencer

This block produces the effective memory address for every cycle of a four-word burst. A load cycle captures a fresh external address and opens a burst. Each following advance cycle moves the two low-order address bits to the next word of the four-word group, and the upper bits stay where the load put them. A static order input picks one of two orders. The linear order counts upward and wraps inside the group. The interleaved order XORs the starting word with the running count.

The state also follows the control rules of a pipelined synchronous memory. A load issued while the chip-select-valid flag is low ends the current burst. When the active-low clock enable is high, the cycle is frozen. An advance with no burst open does nothing. The effective address and the burst-active flag come straight from registers, so both are valid for the whole cycle after the edge that set them.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, eff_addr is all zeros and burst_active is 0.
- R2: A cycle with clk_en_n=0, advance=0 and sel_ok=1 loads the design. From the next cycle, eff_addr equals the addr_in sampled at that edge, burst_active is 1, and the burst count restarts at 0.
- R3: During an active burst, an advance cycle (clk_en_n=0, advance=1) ignores addr_in. It leaves eff_addr bits [AW-1:2] unchanged.
- R4: With order_ilv=0, the low two bits of eff_addr after k advances since the load are (s + k) mod 4, where s is the low two bits of the loaded address.
- R5: With order_ilv=1, the low two bits after k advances are s XOR (k mod 4).
- R6: The fifth word of a burst, reached after four advances, wraps back to the starting word. The burst never carries into bit 2 or above.
- R7: A load cycle with sel_ok=0 sets burst_active to 0 on the next cycle. It leaves eff_addr unchanged.
- R8: An advance cycle while burst_active is 0 leaves eff_addr unchanged and keeps burst_active at 0.
- R9: While clk_en_n=1, eff_addr and burst_active hold their values whatever advance, sel_ok and addr_in do.
- R10: A selected load issued during a burst restarts the sequence at the new address with count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the cycle |
| advance | input | 1 | 1 = advance the burst, 0 = load a new address |
| sel_ok | input | 1 | Chip-select-valid flag, sampled on load cycles |
| order_ilv | input | 1 | Static order select: 1 interleaved, 0 linear |
| addr_in | input | AW | External address |
| eff_addr | output | AW | Effective address for the current cycle |
| burst_active | output | 1 | A burst is open |

## Verification
The bench sweeps all four starting words under both orders, with several upper-address patterns, through six advances each. That run crosses the group boundary. A design that carried into bit 2 would change the upper bits there, and a design that swapped the two orders would give the wrong word at the third step from starts 1 and 3. While advancing, the bench drives a different address on addr_in. A design that loaded on advance would then show that address. The bench also fires loads while the clock enable is high, loads with sel_ok low, and advances when no burst is open. A design that ignored the clock enable, failed to close the burst on a deselect, or counted without an open burst would show a changed address or a wrong active flag on the next cycle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int WORD_BITS = 2;

  typedef enum logic [1:0] {
    EV_IDLE = 2'd0,
    EV_LOAD = 2'd1,
    EV_STEP = 2'd2,
    EV_TERM = 2'd3
  } bseq_ev_e;

  // linear order: wrap-around add within the group
  function automatic logic [WORD_BITS-1:0] lin_word(
    input logic [WORD_BITS-1:0] start,
    input logic [WORD_BITS-1:0] cnt
  );
    return start + cnt;
  endfunction

  // interleaved order: start XOR count
  function automatic logic [WORD_BITS-1:0] ilv_word(
    input logic [WORD_BITS-1:0] start,
    input logic [WORD_BITS-1:0] cnt
  );
    return start ^ cnt;
  endfunction
endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clk_en_n,
  input  logic     advance,
  input  logic     sel_ok,
  output bseq_ev_e ev,
  output logic     active
);
  always_comb begin
    if (clk_en_n)      ev = EV_IDLE;
    else if (!advance) ev = sel_ok ? EV_LOAD : EV_TERM;
    else if (active)   ev = EV_STEP;
    else               ev = EV_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              active <= 1'b0;
    else if (ev == EV_LOAD)  active <= 1'b1;
    else if (ev == EV_TERM)  active <= 1'b0;
  end
endmodule

// File: rtl/bseq_count.sv
module bseq_count
  import bseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  bseq_ev_e             ev,
  output logic [WORD_BITS-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (ev == EV_LOAD) cnt <= '0;
    else if (ev == EV_STEP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bseq_base.sv
module bseq_base
  import bseq_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bseq_ev_e      ev,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] base
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             base <= '0;
    else if (ev == EV_LOAD) base <= addr_in;
  end
endmodule

// File: rtl/bseq_order.sv
module bseq_order
  import bseq_pkg::*;
(
  input  logic                 order_ilv,
  input  logic [WORD_BITS-1:0] start,
  input  logic [WORD_BITS-1:0] cnt,
  output logic [WORD_BITS-1:0] word
);
  logic [WORD_BITS-1:0] lin_w, ilv_w;
  assign lin_w = lin_word(start, cnt);
  assign ilv_w = ilv_word(start, cnt);
  assign word  = order_ilv ? ilv_w : lin_w;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en_n,
  input  logic          advance,
  input  logic          sel_ok,
  input  logic          order_ilv,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] eff_addr,
  output logic          burst_active
);
  localparam int UPPER_W = AW - WORD_BITS;

  bseq_ev_e             ev;
  logic [WORD_BITS-1:0] cnt;
  logic [AW-1:0]        base;
  logic [WORD_BITS-1:0] word;

  // named events for the checker
  logic ev_load, ev_step, ev_term;
  assign ev_load = (ev == EV_LOAD);
  assign ev_step = (ev == EV_STEP);
  assign ev_term = (ev == EV_TERM);

  bseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .advance(advance),
    .sel_ok(sel_ok), .ev(ev), .active(burst_active)
  );

  bseq_count u_count (
    .clk(clk), .rst_n(rst_n), .ev(ev), .cnt(cnt)
  );

  bseq_base #(.AW(AW)) u_base (
    .clk(clk), .rst_n(rst_n), .ev(ev), .addr_in(addr_in), .base(base)
  );

  bseq_order u_order (
    .order_ilv(order_ilv), .start(base[WORD_BITS-1:0]), .cnt(cnt), .word(word)
  );

  assign eff_addr = {base[AW-1 -: UPPER_W], word};
endmodule

module burst_addr_seq_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          advance,
  input logic          sel_ok,
  input logic          order_ilv,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] eff_addr,
  input logic          burst_active,
  input logic          ev_load,
  input logic          ev_step,
  input logic          ev_term
);
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !advance && sel_ok) |=> (burst_active && eff_addr == $past(addr_in)));

  // R3
  upper_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> (eff_addr[AW-1:2] == $past(eff_addr[AW-1:2])));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && !order_ilv) |=> (eff_addr[1:0] == $past(eff_addr[1:0]) + 2'd1));

  // R7
  deselect_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_term |=> (!burst_active && $stable(eff_addr)));

  // R8
  idle_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && advance && !burst_active) |=> (!burst_active && $stable(eff_addr)));

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(eff_addr) && $stable(burst_active)));

  // R9
  freeze_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |-> !(ev_load || ev_step || ev_term));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .advance(advance),
  .sel_ok(sel_ok), .order_ilv(order_ilv), .addr_in(addr_in),
  .eff_addr(eff_addr), .burst_active(burst_active),
  .ev_load(ev_load), .ev_step(ev_step), .ev_term(ev_term)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en_n = 1'b0;
  logic          advance = 1'b1;
  logic          sel_ok = 1'b1;
  logic          order_ilv = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] eff_addr;
  logic          burst_active;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .advance(advance),
    .sel_ok(sel_ok), .order_ilv(order_ilv), .addr_in(addr_in),
    .eff_addr(eff_addr), .burst_active(burst_active)
  );

  task automatic check(input string req, input logic [AW-1:0] exp_a, input logic exp_v);
    compared++;
    if (eff_addr !== exp_a || burst_active !== exp_v) begin
      mismatched++;
      $display("FAIL %s: addr=%h act=%0b expected addr=%h act=%0b",
               req, eff_addr, burst_active, exp_a, exp_v);
    end
  endtask

  // drive at negedge, one edge passes, sample at next negedge
  task automatic cyc(input logic cen_n, input logic adv, input logic sel, input logic [AW-1:0] a);
    clk_en_n = cen_n; advance = adv; sel_ok = sel; addr_in = a;
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] ld, input int k, input logic ilv);
    int s;
    int w;
    s = ld % 4;
    w = ilv ? (s ^ (k % 4)) : ((s + k) % 4);
    return (ld / 4) * 4 + w;
  endfunction

  initial begin
    logic [AW-1:0] uppers[3];
    logic [AW-1:0] ld;
    uppers[0] = 19'h00000; uppers[1] = 19'h5A5A4; uppers[2] = 19'h7FFFC;
    @(negedge clk);
    check("R1", '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: advance before any burst
    cyc(1'b0, 1'b1, 1'b1, 19'h12345);
    check("R8", '0, 1'b0);

    // R2/R3/R4/R5/R6 sweep
    for (int o = 0; o < 2; o++) begin
      order_ilv = o[0];
      for (int u = 0; u < 3; u++) begin
        for (int s = 0; s < 4; s++) begin
          ld = uppers[u] | AW'(s);
          cyc(1'b0, 1'b0, 1'b1, ld);
          check("R2", ld, 1'b1);
          for (int k = 1; k <= 6; k++) begin
            cyc(1'b0, 1'b1, 1'b1, ~ld);
            if (k >= 4) check("R6", expect_addr(ld, k, o[0]), 1'b1);
            else if (o == 1) check("R5", expect_addr(ld, k, 1'b1), 1'b1);
            else check("R4", expect_addr(ld, k, 1'b0), 1'b1);
          end
          if (eff_addr[AW-1:2] !== ld[AW-1:2]) begin
            compared++; mismatched++;
            $display("FAIL R3: upper=%h expected %h", eff_addr[AW-1:2], ld[AW-1:2]);
          end else compared++;
        end
      end
    end

    // R9: freeze mid-burst, including a load attempt
    order_ilv = 1'b0;
    ld = 19'h0ABC1;
    cyc(1'b0, 1'b0, 1'b1, ld);
    cyc(1'b0, 1'b1, 1'b1, '0);
    check("R4", expect_addr(ld, 1, 1'b0), 1'b1);
    cyc(1'b1, 1'b0, 1'b1, 19'h11111);
    check("R9", expect_addr(ld, 1, 1'b0), 1'b1);
    cyc(1'b1, 1'b1, 1'b1, 19'h22222);
    check("R9", expect_addr(ld, 1, 1'b0), 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 19'h33333);
    check("R9", expect_addr(ld, 1, 1'b0), 1'b1);
    cyc(1'b0, 1'b1, 1'b1, '0);
    check("R9", expect_addr(ld, 2, 1'b0), 1'b1);

    // R10: reload mid-burst
    ld = 19'h30002;
    order_ilv = 1'b1;
    cyc(1'b0, 1'b0, 1'b1, ld);
    check("R10", ld, 1'b1);
    cyc(1'b0, 1'b1, 1'b1, '0);
    check("R10", expect_addr(ld, 1, 1'b1), 1'b1);

    // R7: deselect ends the burst, address held
    cyc(1'b0, 1'b0, 1'b0, 19'h44444);
    check("R7", expect_addr(ld, 1, 1'b1), 1'b0);
    // R8: advance after termination does nothing
    cyc(1'b0, 1'b1, 1'b1, 19'h55555);
    check("R8", expect_addr(ld, 1, 1'b1), 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 19'h66666);
    check("R8", expect_addr(ld, 1, 1'b1), 1'b0);

    // R1: reset again mid-burst
    cyc(1'b0, 1'b0, 1'b1, 19'h7AAA7);
    rst_n = 1'b0;
    #1;
    check("R1", '0, 1'b0);
    done = 1;
  end

  initial begin
    int cycles = 0;
    while (!done && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule